// File: doc/BRIEF.md
# Register-Steered Merged 3x3 Image Filter

This unit hangs off the IP bus of a small stack processor and offers five 3x3 image filters through one set of shared arithmetic. A stored selector picks which filter the datapath currently behaves as, so the processor always sees a single unit with a fixed stack footprint: three words in, one word out.

The unit owns two adjacent operation codes. The lower code (`BASE_CODE`) applies the selected filter, combinationally and within the same cycle, to nine 8-bit pixels unpacked from three stack words. The upper code (`BASE_CODE + 1`) copies the top-of-stack word into the selector at the next clock edge. Switching filters therefore costs exactly one cycle, and the following compute uses the new filter.

The weighted filters come from two channels of chained adder/subtractor stages whose per-tap sign, shift and enable follow the selector. The median comes from a compare-exchange sorting network.

Top module: `merged_filter_unit`

## Requirements
- R1: Any `op_code` other than `BASE_CODE` (default 164) and `BASE_CODE + 1` drives `result` to 0 and leaves the selected filter unchanged.
- R2: After reset, the selector is 0, and a compute runs the Gaussian filter.
- R3: With `op_code == BASE_CODE + 1` at a rising edge, selector bits 2:0 take `stk_w0[2:0]`. The compute in the next cycle uses the new filter, and `result` is 0 during the load cycle.
- R4: Pixels p0..p8 are in row-major order. p0..p3 are bytes 0..3 of `stk_w0` (p0 in bits 7:0), p4..p7 are bytes 0..3 of `stk_w1`, and p8 is `stk_w2[7:0]`. Bits 31:8 of `stk_w2` have no effect.
- R5: Selector 0 gives Gaussian: (p0+p2+p6+p8 + 2(p1+p3+p5+p7) + 4p4) >> 4.
- R6: Selector 1 gives mean: ((p0+...+p8) * 7282) >> 16.
- R7: Selector 2 gives diagonal Prewitt: min(255, |p1+p2-p3+p5-p6-p7| + |-p0-p1-p3+p5+p7+p8|).
- R8: Selector 3 gives Sobel: min(255, |-p0+p2-2p3+2p5-p6+p8| + |-p0-2p1-p2+p6+2p7+p8|).
- R9: Selector 4 gives the median (5th smallest) of the nine pixels.
- R10: Selector values 5, 6 and 7 behave as the Gaussian filter.
- R11: During a compute, `result[31:8]` is always 0 and the filter value is in `result[7:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 10 | Operation code from the processor |
| stk_w0 | input | 32 | Top stack word: pixels p0..p3, or the new selector on a load |
| stk_w1 | input | 32 | Second stack word: pixels p4..p7 |
| stk_w2 | input | 32 | Third stack word: pixel p8 in bits 7:0 |
| result | output | 32 | Filter output word, 0 when not computing |

## Verification
On every cycle, the assertions check four things:
- Foreign codes leave the selector untouched and the output at zero.
- A load code captures the low bits of the top word into the selector.
- The upper 24 output bits stay clear.
- A median output always equals one of the nine input pixel fields.

The arithmetic values of each filter can be shown only by the bench, which compares them with its own model. The bench sweeps every selector value, including the three fallback encodings, over corner and random pixel sets. It also runs the order-dependent scenarios: reset default, a compute right after a load, and foreign codes carrying a selector value on the top word.

// File: rtl/imgflt_pkg.sv
package imgflt_pkg;
    localparam int WORD_W = 32;
    localparam int PIX_W  = 8;
    localparam int NPIX   = 9;
    localparam int CODE_W = 10;
    localparam int CFG_W  = 3;
    localparam int SUM_W  = 14;

    typedef logic [PIX_W-1:0] pix_t;

    typedef enum logic [CFG_W-1:0] {
        F_GAUSS  = 3'd0,
        F_MEAN   = 3'd1,
        F_DIAG   = 3'd2,
        F_SOBEL  = 3'd3,
        F_MEDIAN = 3'd4
    } fsel_e;

    // per-tap control of one adder/subtractor stage
    typedef struct packed {
        logic       en;
        logic       neg;
        logic [1:0] shamt;
    } tap_t;

    typedef struct packed {
        logic [CFG_W-1:0] sel;
    } state_t;

    // signed kernel weight of tap i on channel a (chan_b=0) or b (chan_b=1)
    function automatic int tap_weight(fsel_e f, logic chan_b, int i);
        int w;
        w = 0;
        case (f)
            F_GAUSS: if (!chan_b) w = (i == 4) ? 4 : ((i % 2) == 1 ? 2 : 1);
            F_MEAN:  if (!chan_b) w = 1;
            F_DIAG: begin
                if (!chan_b) begin
                    case (i)
                        1, 2, 5: w = 1;
                        3, 6, 7: w = -1;
                        default: w = 0;
                    endcase
                end else begin
                    case (i)
                        0, 1, 3: w = -1;
                        5, 7, 8: w = 1;
                        default: w = 0;
                    endcase
                end
            end
            F_SOBEL: begin
                if (!chan_b) begin
                    case (i)
                        0, 6:    w = -1;
                        2, 8:    w = 1;
                        3:       w = -2;
                        5:       w = 2;
                        default: w = 0;
                    endcase
                end else begin
                    case (i)
                        0, 2:    w = -1;
                        6, 8:    w = 1;
                        1:       w = -2;
                        7:       w = 2;
                        default: w = 0;
                    endcase
                end
            end
            default: w = 0;
        endcase
        return w;
    endfunction

    function automatic tap_t to_tap(int w);
        tap_t t;
        int   m;
        m       = (w < 0) ? -w : w;
        t.en    = (w != 0);
        t.neg   = (w < 0);
        t.shamt = (m == 4) ? 2'd2 : ((m == 2) ? 2'd1 : 2'd0);
        return t;
    endfunction
endpackage

// File: rtl/imgflt_addsub.sv
module imgflt_addsub #(
    parameter int W = 14
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    always_comb begin
        y = sub ? (a - b) : (a + b);
    end
endmodule

// File: rtl/imgflt_wsum.sv
module imgflt_wsum
    import imgflt_pkg::*;
#(
    parameter int N = 9,
    parameter int W = 14
) (
    input  pix_t [N-1:0] pix,
    input  tap_t [N-1:0] taps,
    output logic [W-1:0] sum
);
    logic [W-1:0] acc  [0:N];
    logic [W-1:0] term [0:N-1];

    assign acc[0] = '0;

    for (genvar i = 0; i < N; i++) begin : g_tap
        always_comb begin
            term[i] = '0;
            if (taps[i].en)
                term[i] = W'({pix[i]} << taps[i].shamt);
        end

        imgflt_addsub #(.W(W)) u_as (
            .a   (acc[i]),
            .b   (term[i]),
            .sub (taps[i].neg),
            .y   (acc[i+1])
        );
    end

    assign sum = acc[N];
endmodule

// File: rtl/imgflt_cmpx.sv
module imgflt_cmpx #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi
);
    logic a_gt;
    always_comb begin
        a_gt = (a > b);
        lo   = a_gt ? b : a;
        hi   = a_gt ? a : b;
    end
endmodule

// File: rtl/imgflt_median.sv
module imgflt_median
    import imgflt_pkg::*;
#(
    parameter int N = 9
) (
    input  pix_t [N-1:0] pix,
    output pix_t         med
);
    // odd-even transposition sort, N stages
    pix_t stg [0:N][0:N-1];

    for (genvar j = 0; j < N; j++) begin : g_in
        assign stg[0][j] = pix[j];
    end

    for (genvar s = 0; s < N; s++) begin : g_stage
        for (genvar j = 0; j < N; j++) begin : g_lane
            if (((j % 2) == (s % 2)) && (j + 1 < N)) begin : g_cx
                imgflt_cmpx #(.W(PIX_W)) u_cx (
                    .a  (stg[s][j]),
                    .b  (stg[s][j+1]),
                    .lo (stg[s+1][j]),
                    .hi (stg[s+1][j+1])
                );
            end else if (!((j >= 1) && (((j - 1) % 2) == (s % 2)))) begin : g_pass
                assign stg[s+1][j] = stg[s][j];
            end
        end
    end

    assign med = stg[N][N/2];
endmodule

// File: rtl/merged_filter_unit.sv
module merged_filter_unit
    import imgflt_pkg::*;
#(
    parameter logic [9:0] BASE_CODE = 10'd164,
    parameter int         MEAN_MUL  = 7282,
    parameter int         MEAN_SH   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [9:0]  op_code,
    input  logic [31:0] stk_w0,
    input  logic [31:0] stk_w1,
    input  logic [31:0] stk_w2,
    output logic [31:0] result
);
    localparam logic [CODE_W-1:0] CFG_CODE = BASE_CODE + 10'd1;
    localparam int PROD_W   = SUM_W + $clog2(MEAN_MUL + 1);
    localparam int GAUSS_SH = 4;
    localparam int MAG_W    = SUM_W + 1;

    state_t state_d, state_q;
    logic   run_hit, cfg_hit;
    logic [CFG_W-1:0] cfg_q;

    pix_t [NPIX-1:0] pix;
    tap_t [NPIX-1:0] taps_a, taps_b;
    fsel_e           act;

    logic [SUM_W-1:0]  sum_a, sum_b;
    logic [SUM_W-1:0]  abs_a, abs_b;
    logic [MAG_W-1:0]  mag;
    logic [PROD_W-1:0] prod;
    pix_t              med, filt;

    // operation decode
    assign run_hit = (op_code == BASE_CODE);
    assign cfg_hit = (op_code == CFG_CODE);

    // pixel unpacking, row-major
    for (genvar k = 0; k < NPIX; k++) begin : g_unpack
        if (k < 4) begin : g_w0
            assign pix[k] = stk_w0[PIX_W*k +: PIX_W];
        end else if (k < 8) begin : g_w1
            assign pix[k] = stk_w1[PIX_W*(k-4) +: PIX_W];
        end else begin : g_w2
            assign pix[k] = stk_w2[PIX_W-1:0];
        end
    end

    // selector to active filter; unused encodings fall back to Gaussian
    always_comb begin
        case (state_q.sel)
            3'd1:    act = F_MEAN;
            3'd2:    act = F_DIAG;
            3'd3:    act = F_SOBEL;
            3'd4:    act = F_MEDIAN;
            default: act = F_GAUSS;
        endcase
    end

    // per-tap steering of the shared adder/subtractor chains
    always_comb begin
        for (int i = 0; i < NPIX; i++) begin
            taps_a[i] = to_tap(tap_weight(act, 1'b0, i));
            taps_b[i] = to_tap(tap_weight(act, 1'b1, i));
        end
    end

    imgflt_wsum #(.N(NPIX), .W(SUM_W)) u_chan_a (
        .pix  (pix),
        .taps (taps_a),
        .sum  (sum_a)
    );

    imgflt_wsum #(.N(NPIX), .W(SUM_W)) u_chan_b (
        .pix  (pix),
        .taps (taps_b),
        .sum  (sum_b)
    );

    imgflt_median #(.N(NPIX)) u_median (
        .pix (pix),
        .med (med)
    );

    // post-processing and output select
    always_comb begin
        abs_a = sum_a[SUM_W-1] ? (~sum_a + 1'b1) : sum_a;
        abs_b = sum_b[SUM_W-1] ? (~sum_b + 1'b1) : sum_b;
        mag   = {1'b0, abs_a} + {1'b0, abs_b};
        prod  = PROD_W'(sum_a) * PROD_W'(MEAN_MUL);
        case (act)
            F_MEAN:   filt = prod[MEAN_SH +: PIX_W];
            F_DIAG,
            F_SOBEL:  filt = (mag > MAG_W'(255)) ? 8'hFF : mag[PIX_W-1:0];
            F_MEDIAN: filt = med;
            default:  filt = sum_a[GAUSS_SH +: PIX_W];
        endcase
        result = run_hit ? {{(WORD_W-PIX_W){1'b0}}, filt} : '0;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (cfg_hit)
            state_d.sel = stk_w0[CFG_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign cfg_q = state_q.sel;

    logic unused_bits;
    assign unused_bits = ^{stk_w2[WORD_W-1:PIX_W], stk_w0[WORD_W-1:CFG_W] & 29'd0,
                           prod, sum_b, mag};
endmodule

// File: rtl/imgflt_chk.sv
module imgflt_chk #(
    parameter logic [9:0] BASE_CODE = 10'd164
) (
    input logic        clk,
    input logic        rst_n,
    input logic [9:0]  op_code,
    input logic [31:0] stk_w0,
    input logic [31:0] stk_w1,
    input logic [31:0] stk_w2,
    input logic [31:0] result,
    input logic [2:0]  cfg_q
);
    logic foreign;
    assign foreign = (op_code != BASE_CODE) && (op_code != BASE_CODE + 10'd1);

    // R1
    foreign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        foreign |-> (result == 32'd0));

    // R1
    foreign_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        foreign |=> $stable(cfg_q));

    // R3
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == BASE_CODE + 10'd1) |=> (cfg_q == $past(stk_w0[2:0])));

    // R11
    upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result[31:8] == 24'd0);

    // R9
    median_member_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_code == BASE_CODE) && (cfg_q == 3'd4)) |->
        (result[7:0] == stk_w0[7:0]   || result[7:0] == stk_w0[15:8]  ||
         result[7:0] == stk_w0[23:16] || result[7:0] == stk_w0[31:24] ||
         result[7:0] == stk_w1[7:0]   || result[7:0] == stk_w1[15:8]  ||
         result[7:0] == stk_w1[23:16] || result[7:0] == stk_w1[31:24] ||
         result[7:0] == stk_w2[7:0]));
endmodule

bind merged_filter_unit imgflt_chk #(.BASE_CODE(BASE_CODE)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_code (op_code),
    .stk_w0  (stk_w0),
    .stk_w1  (stk_w1),
    .stk_w2  (stk_w2),
    .result  (result),
    .cfg_q   (cfg_q)
);

// File: tb/merged_filter_unit_tb.sv
module merged_filter_unit_tb;
    localparam logic [9:0] RUN = 10'd164;
    localparam logic [9:0] LDC = 10'd165;
    localparam logic [9:0] IDLE = 10'd0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  op_code = IDLE;
    logic [31:0] stk_w0 = '0, stk_w1 = '0, stk_w2 = '0;
    logic [31:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    merged_filter_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code),
        .stk_w0(stk_w0), .stk_w1(stk_w1), .stk_w2(stk_w2), .result(result)
    );

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int sat(int v);
        return (v > 255) ? 255 : v;
    endfunction

    function automatic int model(int sel, int p[9]);
        int q[9];
        int t;
        case (sel)
            1: return ((p[0]+p[1]+p[2]+p[3]+p[4]+p[5]+p[6]+p[7]+p[8]) * 7282) >>> 16;
            2: return sat(iabs(p[1]+p[2]-p[3]+p[5]-p[6]-p[7]) +
                          iabs(-p[0]-p[1]-p[3]+p[5]+p[7]+p[8]));
            3: return sat(iabs(-p[0]+p[2]-2*p[3]+2*p[5]-p[6]+p[8]) +
                          iabs(-p[0]-2*p[1]-p[2]+p[6]+2*p[7]+p[8]));
            4: begin
                q = p;
                for (int a = 0; a < 9; a++)
                    for (int b = 0; b < 8 - a; b++)
                        if (q[b] > q[b+1]) begin t = q[b]; q[b] = q[b+1]; q[b+1] = t; end
                return q[4];
            end
            default: return (p[0]+p[2]+p[6]+p[8] + 2*(p[1]+p[3]+p[5]+p[7]) + 4*p[4]) >>> 4;
        endcase
    endfunction

    function automatic string tag(int sel);
        case (sel)
            0: return "R5";
            1: return "R6";
            2: return "R7";
            3: return "R8";
            4: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // load selector: upper bits of the top word carry junk
    task automatic load_cfg(int sel);
        @(negedge clk);
        op_code = LDC;
        stk_w0  = {$urandom} & 32'hFFFF_FFF8 | 32'(sel);
        #2;
        check("R3 load cycle output", result, 32'd0);
        @(negedge clk);
        op_code = IDLE;
    endtask

    // drive a compute with the given pixels and check (R4 junk in w2 upper bits, R11)
    task automatic run_chk(int sel, int p[9], string req);
        @(negedge clk);
        op_code = RUN;
        stk_w0 = {p[3][7:0], p[2][7:0], p[1][7:0], p[0][7:0]};
        stk_w1 = {p[7][7:0], p[6][7:0], p[5][7:0], p[4][7:0]};
        stk_w2 = {$urandom} & 32'hFFFF_FF00 | 32'(p[8] & 255);
        #2;
        check(req, result, 32'(model(sel, p)));
    endtask

    task automatic make_pat(int idx, output int p[9]);
        for (int k = 0; k < 9; k++) begin
            case (idx)
                0: p[k] = 0;
                1: p[k] = 255;
                2: p[k] = (k % 2) ? 255 : 0;
                3: p[k] = (k == 4) ? 255 : 0;
                4: p[k] = k * 28;
                5: p[k] = (k % 3 == 2) ? 255 : 0;
                default: p[k] = $urandom_range(0, 255);
            endcase
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int p[9];
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: reset default is Gaussian
        make_pat(4, p);
        run_chk(0, p, "R2 reset Gaussian");
        make_pat(9, p);
        run_chk(0, p, "R2 reset Gaussian");

        // sweep every selector value
        for (int sel = 0; sel < 8; sel++) begin
            load_cfg(sel);
            for (int idx = 0; idx < 150; idx++) begin
                make_pat(idx, p);
                run_chk(sel, p, tag(sel));
            end
        end

        // R11: saturating case, upper bits clear
        load_cfg(3);
        make_pat(5, p);
        run_chk(3, p, "R11 upper bits with Sobel");

        // R1: foreign codes give 0 and leave the selector alone
        load_cfg(1);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            op_code = (c == 0) ? (RUN - 10'd1) : (c == 1) ? (RUN + 10'd2) :
                      (c == 2) ? 10'd0 : 10'h3FF;
            stk_w0 = 32'd4;
            #2;
            check("R1 foreign code output", result, 32'd0);
        end
        make_pat(7, p);
        run_chk(1, p, "R1 selector unchanged");

        // R3: back-to-back load then compute uses new filter
        load_cfg(4);
        make_pat(8, p);
        run_chk(4, p, "R3 next compute new filter");
        load_cfg(2);
        run_chk(2, p, "R3 next compute new filter");

        // R4: pixel order, single nonzero pixel at each position under Sobel
        load_cfg(3);
        for (int k = 0; k < 9; k++) begin
            for (int m = 0; m < 9; m++) p[m] = (m == k) ? 40 + k : 0;
            run_chk(3, p, "R4 pixel position");
        end

        @(negedge clk);
        op_code = IDLE;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule